// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Guard

This block keeps the protection state of a small serial flash device. It holds a write-enable latch, two block-protect bits that choose how much of the top of the array is locked, and a protect-enable bit that decides whether the external write-protect pin has any effect. The serial front end sends it decoded command strobes and the current target address. From these it produces two combinational permits: one for array writes and one for status writes. It also supplies the byte that a status read shifts out.

A status-write command is run by a three-state machine. `SR_IDLE` accepts a status-write strobe (transition *accept*) only if the latch is set, no write cycle is running and hardware protection is off, and moves to `SR_ARMED`. `SR_ARMED` waits for chip select to rise (transition *launch*) and then moves to `SR_BURN`. If hardware protection becomes active while chip select is still low, it returns to `SR_IDLE` instead (transition *cancel*). `SR_BURN` counts a parameterised number of clocks, then writes the new protection bits, clears the latch and returns to `SR_IDLE` (transition *commit*). The array engine reports its own busy time and completion through two inputs, so that the busy bit and the automatic clearing of the latch cover every kind of write.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte is 0x00, the write-enable latch, both block-protect bits and protect enable are 0, and both permits are low.
- R2: When no write cycle runs, the status byte is {protect enable at bit 7, zeros at bits 6..4, block-protect level at bits 3..2, write enable at bit 1, busy at bit 0}.
- R3: A set-enable strobe sets the write-enable latch. A clear-enable strobe clears it whatever the level of `wp_n`. Both strobes are ignored while a write cycle runs.
- R4: The write-enable latch clears when a status-write cycle commits, and on an `arr_done` pulse that reports the end of an array program or erase.
- R5: `arr_permit` is high only when write enable is set, no cycle runs, and `arr_addr` lies outside the locked range. The locked range is none for level 0; addresses whose top two bits are 11 for level 1; addresses whose top bit is 1 for level 2; every address for level 3.
- R6: A status-write strobe with write enable clear changes nothing and starts no cycle.
- R7: An accepted status write starts when `cs_n` rises and lasts SR_CYCLES clocks. It then loads only data bits 7, 3 and 2 into protect enable and the block-protect bits. All other data bits are ignored.
- R8: While any write cycle runs, the status byte reads 0xFF.
- R9: When `wp_n` is low and protect enable is 1, status writes are refused, including one that clears protect enable, and `sr_permit` is low.
- R10: When protect enable is 0, a low `wp_n` neither blocks status writes nor lowers `sr_permit`.
- R11: If hardware protection becomes active after the strobe while `cs_n` is still low, the status write is cancelled, with no busy time, no bit change and the latch left set. Once the cycle has started, `wp_n` has no effect on it.
- R12: `arr_busy` high sets the busy bit and blocks both permits and the enable strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select from the serial front end, low while selected |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_set_we | input | 1 | Strobe: set the write-enable latch |
| cmd_clr_we | input | 1 | Strobe: clear the write-enable latch |
| cmd_wrsr | input | 1 | Strobe: status-write data byte received |
| wrsr_data | input | 8 | Status-write data byte |
| arr_busy | input | 1 | Array program or erase cycle in progress |
| arr_done | input | 1 | Pulse at the end of an array cycle |
| arr_addr | input | ADDR_W | Target byte address of an array write |
| status_byte | output | 8 | Byte returned by a status read |
| arr_permit | output | 1 | Array write at `arr_addr` is allowed |
| sr_permit | output | 1 | Status write would be accepted now |

## Verification
A latch that is stuck or cleared at the wrong time shows in bit 1 of the status byte and in both permits on the next clock. A wrong block-protect level shows in the permit that the address vectors check in the same cycle. A state machine that launches, cancels or ends at the wrong point shows as a busy byte of 0xFF one clock after `cs_n` rises, or the lack of one. It also shows as a wrong cycle length, or as protection bits that differ from the expected value once the cycle has ended. A refused or cancelled write shows only as unchanged status bits, so every such case is followed by a status read.

// File: rtl/stguard_pkg.sv
package stguard_pkg;
    typedef enum logic [1:0] {
        SR_IDLE,
        SR_ARMED,
        SR_BURN
    } sr_state_e;

    localparam int STAT_W   = 8;
    localparam int BIT_WPEN = 7;
    localparam int BIT_BP1  = 3;
    localparam int BIT_BP0  = 2;
    localparam int BIT_WE   = 1;
    localparam int BIT_BUSY = 0;

    localparam logic [1:0] LVL_NONE    = 2'b00;
    localparam logic [1:0] LVL_QUARTER = 2'b01;
    localparam logic [1:0] LVL_HALF    = 2'b10;
    localparam logic [1:0] LVL_ALL     = 2'b11;
endpackage

// File: rtl/stg_lock_map.sv
module stg_lock_map #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    import stguard_pkg::*;

    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (level)
            LVL_NONE:    locked = 1'b0;
            LVL_QUARTER: locked = addr[TOP] & addr[TOP-1];
            LVL_HALF:    locked = addr[TOP];
            LVL_ALL:     locked = 1'b1;
            default:     locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/stg_wel.sv
module stg_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic busy,
    input  logic auto_clr,
    output logic we
);
    logic we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b0;
        end else if (auto_clr) begin
            we_q <= 1'b0;
        end else if (!busy) begin
            if (clr_req)      we_q <= 1'b0;
            else if (set_req) we_q <= 1'b1;
        end
    end

    assign we = we_q;

    AST_WE_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        auto_clr |=> !we_q); // R4
    AST_WE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !auto_clr) |=> $stable(we_q)); // R3
endmodule

// File: rtl/stg_sr_fsm.sv
module stg_sr_fsm #(
    parameter int SR_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wp_n,
    input  logic       wrsr_req,
    input  logic [7:0] wrsr_data,
    input  logic       we,
    input  logic       ext_busy,
    output logic [1:0] bp,
    output logic       wpen,
    output logic       hw_prot,
    output logic       burning,
    output logic       commit
);
    import stguard_pkg::*;

    localparam int CNT_W = $clog2(SR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SR_CYCLES - 1);

    sr_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       shadow_q;
    logic [1:0]       bp_q;
    logic             wpen_q;
    logic             accept, launch, cancel, done;

    assign hw_prot = !wp_n && wpen_q;
    assign accept  = (state_q == SR_IDLE) && wrsr_req && we && !ext_busy && !hw_prot;
    assign cancel  = (state_q == SR_ARMED) && !cs_n && hw_prot;
    assign launch  = (state_q == SR_ARMED) && cs_n;
    assign done    = (state_q == SR_BURN) && (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE:  if (accept) state_d = SR_ARMED;
            SR_ARMED: begin
                if (cancel)      state_d = SR_IDLE;
                else if (launch) state_d = SR_BURN;
            end
            SR_BURN:  if (done) state_d = SR_IDLE;
            default:  state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SR_IDLE;
            cnt_q    <= '0;
            shadow_q <= '0;
            bp_q     <= LVL_NONE;
            wpen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                shadow_q <= {wrsr_data[BIT_WPEN], wrsr_data[BIT_BP1], wrsr_data[BIT_BP0]};
            end
            if (state_q == SR_BURN) cnt_q <= done ? '0 : cnt_q + 1'b1;
            else                    cnt_q <= '0;
            if (done) begin
                wpen_q <= shadow_q[2];
                bp_q   <= shadow_q[1:0];
            end
        end
    end

    always_comb begin
        bp      = bp_q;
        wpen    = wpen_q;
        burning = (state_q == SR_BURN);
        commit  = done;
    end

    AST_HW_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_IDLE && hw_prot) |=> (state_q != SR_ARMED)); // R9
    AST_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_IDLE && !we) |=> (state_q != SR_ARMED)); // R6
    AST_CANCEL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_ARMED && !cs_n && hw_prot) |=> (state_q == SR_IDLE)); // R11
    AST_BITS_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(bp_q) && $stable(wpen_q))); // R7
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_BURN) |-> (cnt_q <= CNT_LAST)); // R7
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
    parameter int ADDR_W    = 17,
    parameter int SR_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_set_we,
    input  logic              cmd_clr_we,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              arr_busy,
    input  logic              arr_done,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status_byte,
    output logic              arr_permit,
    output logic              sr_permit
);
    import stguard_pkg::*;

    logic       we, hw_prot, burning, commit, locked, wpen, any_busy;
    logic [1:0] bp;

    assign any_busy = burning | arr_busy;

    stg_wel u_wel (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (cmd_set_we),
        .clr_req  (cmd_clr_we),
        .busy     (any_busy),
        .auto_clr (commit | arr_done),
        .we       (we)
    );

    stg_sr_fsm #(.SR_CYCLES(SR_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wp_n      (wp_n),
        .wrsr_req  (cmd_wrsr),
        .wrsr_data (wrsr_data),
        .we        (we),
        .ext_busy  (arr_busy),
        .bp        (bp),
        .wpen      (wpen),
        .hw_prot   (hw_prot),
        .burning   (burning),
        .commit    (commit)
    );

    stg_lock_map #(.ADDR_W(ADDR_W)) u_map (
        .level  (bp),
        .addr   (arr_addr),
        .locked (locked)
    );

    always_comb begin
        if (any_busy) begin
            status_byte = '1;
        end else begin
            status_byte           = '0;
            status_byte[BIT_WPEN] = wpen;
            status_byte[BIT_BP1]  = bp[1];
            status_byte[BIT_BP0]  = bp[0];
            status_byte[BIT_WE]   = we;
        end
        arr_permit = we && !any_busy && !locked;
        sr_permit  = we && !any_busy && !hw_prot;
    end

    AST_BUSY_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[BIT_BUSY] |-> (!arr_permit && !sr_permit)); // R12
    AST_PERMIT_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_permit |-> we); // R5
    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        arr_permit |-> (bp != LVL_ALL)); // R5
    AST_SR_PERMIT_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && wpen) |-> !sr_permit); // R9
endmodule

// File: tb/flash_status_guard_test.sv
module flash_status_guard_test;
    localparam int ADDR_W = 17;
    localparam int SRC    = 8;
    localparam int NVEC   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, wp_n = 1'b1;
    logic              cmd_set_we = 1'b0, cmd_clr_we = 1'b0, cmd_wrsr = 1'b0;
    logic [7:0]        wrsr_data = 8'h00;
    logic              arr_busy = 1'b0, arr_done = 1'b0;
    logic [ADDR_W-1:0] arr_addr = '0;
    logic [7:0]        status_byte;
    logic              arr_permit, sr_permit;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // {level[1:0], address[16:0], expected permit}
    localparam logic [19:0] VEC [NVEC] = '{
        {2'b00, 17'h00000, 1'b1},
        {2'b00, 17'h1FFFF, 1'b1},
        {2'b01, 17'h17FFF, 1'b1},
        {2'b01, 17'h18000, 1'b0},
        {2'b01, 17'h1FFFF, 1'b0},
        {2'b10, 17'h0FFFF, 1'b1},
        {2'b10, 17'h10000, 1'b0},
        {2'b10, 17'h17FFF, 1'b0},
        {2'b11, 17'h00000, 1'b0},
        {2'b11, 17'h0FFFF, 1'b0}
    };

    flash_status_guard #(.ADDR_W(ADDR_W), .SR_CYCLES(SRC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_set_we(cmd_set_we), .cmd_clr_we(cmd_clr_we), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .arr_busy(arr_busy), .arr_done(arr_done),
        .arr_addr(arr_addr), .status_byte(status_byte),
        .arr_permit(arr_permit), .sr_permit(sr_permit)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_stat(input string req, input logic [7:0] exp);
        check(status_byte == exp, req, 32'(status_byte), 32'(exp));
    endtask

    task automatic pulse_set();
        cmd_set_we = 1'b1; tick(); cmd_set_we = 1'b0;
    endtask

    task automatic pulse_clr();
        cmd_clr_we = 1'b1; tick(); cmd_clr_we = 1'b0;
    endtask

    // Full status write; checks busy byte after cs_n rises when expected
    task automatic do_wrsr(input logic [7:0] d, input bit exp_busy, input string req);
        cs_n = 1'b0; cmd_wrsr = 1'b1; wrsr_data = d; tick();
        cmd_wrsr = 1'b0; tick();
        cs_n = 1'b1; tick();
        chk_stat(req, exp_busy ? 8'hFF : status_byte & 8'h8E);
        repeat (SRC) tick();
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk_stat("R1", 8'h00);
        check(!arr_permit && !sr_permit, "R1", {arr_permit, sr_permit}, 0);
        rst_n = 1'b1; tick();
        chk_stat("R1", 8'h00);

        // R2, R3: set enable shows at bit 1
        pulse_set();
        chk_stat("R2", 8'h02);
        check(sr_permit, "R3", sr_permit, 1);
        wp_n = 1'b0; pulse_clr();
        chk_stat("R3", 8'h00);
        wp_n = 1'b1;

        // R6: no write enable, status write ignored
        do_wrsr(8'h8C, 1'b0, "R6");
        chk_stat("R6", 8'h00);

        // R5, R7, R4: protection level vectors
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] lv;
            lv = VEC[i][19:18];
            pulse_set();
            do_wrsr({4'b0000, lv, 2'b11}, 1'b1, "R8");
            chk_stat("R7", {4'b0000, lv, 2'b00});
            pulse_set();
            arr_addr = VEC[i][17:1];
            tick();
            check(arr_permit == VEC[i][0], "R5", arr_permit, VEC[i][0]);
            pulse_clr();
            tick();
            check(!arr_permit, "R5", arr_permit, 0);
        end

        // R7: only bits 7,3,2 taken
        pulse_set();
        do_wrsr(8'hF7, 1'b1, "R8");
        chk_stat("R7", 8'h84);

        // R12: array busy
        arr_busy = 1'b1; tick();
        chk_stat("R12", 8'hFF);
        pulse_set(); tick();
        arr_busy = 1'b0; tick();
        chk_stat("R12", 8'h84);

        // R4: array done clears enable
        pulse_set();
        chk_stat("R4", 8'h86);
        arr_done = 1'b1; tick(); arr_done = 1'b0;
        chk_stat("R4", 8'h84);

        // R9: hardware protection blocks status write
        wp_n = 1'b0;
        pulse_set();
        check(!sr_permit, "R9", sr_permit, 0);
        do_wrsr(8'h00, 1'b0, "R9");
        chk_stat("R9", 8'h86);

        // R10: protection enable cleared, pin ignored
        wp_n = 1'b1; tick();
        do_wrsr(8'h00, 1'b1, "R8");
        chk_stat("R10", 8'h00);
        wp_n = 1'b0;
        pulse_set();
        check(sr_permit, "R10", sr_permit, 1);
        do_wrsr(8'h08, 1'b1, "R10");
        chk_stat("R10", 8'h08);

        // R11: cancel while cs_n low
        wp_n = 1'b1;
        pulse_set();
        do_wrsr(8'h80, 1'b1, "R8");
        chk_stat("R11", 8'h80);
        pulse_set();
        cs_n = 1'b0; cmd_wrsr = 1'b1; wrsr_data = 8'h8C; tick();
        cmd_wrsr = 1'b0; wp_n = 1'b0; tick();
        cs_n = 1'b1; tick();
        chk_stat("R11", 8'h82);
        repeat (SRC) tick();
        chk_stat("R11", 8'h82);

        // R11: pin drop after cycle start has no effect
        wp_n = 1'b1; tick();
        cs_n = 1'b0; cmd_wrsr = 1'b1; wrsr_data = 8'h0C; tick();
        cmd_wrsr = 1'b0; tick();
        cs_n = 1'b1; tick();
        wp_n = 1'b0;
        chk_stat("R11", 8'hFF);
        repeat (SRC - 1) tick();
        chk_stat("R7", 8'hFF);
        tick();
        chk_stat("R11", 8'h0C);
        wp_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule